// File: doc/BRIEF.md
# Stack Multi-Register Push/Pop Sequencer

This block carries out one push-multiple or pop-multiple operation of a compact 16-bit instruction set. It takes a bitmap of up to eight low registers, a flag that adds one extra register, a direction bit and the starting stack pointer. The extra register is the link register on a push and the program counter on a pop. The block then moves one 32-bit word per accepted memory access. Register values come from, or go back to, a small register-file port. The working stack pointer moves by one word after every accepted access.

The command input is a valid/ready handshake. `cmd_ready` is high only while the block is idle, so a command is taken in the cycle where both signals are high. The memory port is also valid/ready. A request stays up, with its address and data held unchanged, until `mem_req_ready` is seen high. Read data on `mem_rdata` must be valid in the same cycle in which ready is high. The memory port sets the pace of the block, and a low ready stalls it for as long as it stays low.

When the operation ends, `done_o` pulses for one cycle. With it the block presents the final stack pointer and the sequential (S), non-sequential (N) and internal (I) cycle counts that a timing model charges for this variant. If the program counter was popped, `flush_o` is raised at the same time and `pc_o` holds the new fetch address.

Top module: `stk_multi_seq`

## Requirements
- R1: A push stores the link register (index 14) first when the extra flag is set. It then stores the listed registers in falling index order, so the lowest listed register ends up at the lowest address.
- R2: Each push word is written at stack pointer minus 4. `sp_o` takes that lower value in the cycle after the write is accepted.
- R3: A pop reads the listed registers in rising index order. Each read is at the current stack pointer, and the data goes out on the register-file write port in the accepting cycle. `sp_o` rises by 4 in the following cycle.
- R4: A pop with the extra flag set reads one last word after the listed registers. That word goes to `pc_o` with bit 0 forced to 0 and is not written to the register file. `flush_o` is high only during the `done_o` cycle of such a pop.
- R5: A pop without the extra flag reports S = n, N = 1 and I = 1, where n is the number of listed registers.
- R6: A pop with the extra flag reports S = n + 1, N = 2 and I = 1, where n is the number of listed registers.
- R7: A push reports S = k − 1, N = 2 and I = 0, where k is the number of words stored, including the link register.
- R8: An empty bitmap with the flag clear makes no memory access, leaves `sp_o` equal to the command's stack pointer and reports all three counts as 0.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the request address, direction and data stay unchanged and `sp_o` does not move.
- R10: `done_o` is high for exactly one cycle per command. `cmd_ready` is low from command acceptance until `done_o`.
- R11: After reset, `cmd_ready` is 1 and `mem_req_valid`, `done_o` and `flush_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high together with valid |
| cmd_list | input | LIST_W | Bitmap of low registers |
| cmd_extra | input | 1 | Adds the link register (push) or the program counter (pop) |
| cmd_pop | input | 1 | 1 = pop, 0 = push |
| cmd_sp | input | DATA_W | Stack pointer at the start |
| mem_req_valid | output | 1 | Memory access requested |
| mem_req_ready | input | 1 | Memory accepts the access this cycle |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | DATA_W | Byte address of the word |
| mem_req_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid while ready is high |
| rf_rd_idx | output | 4 | Register-file read index |
| rf_rd_data | input | DATA_W | Register-file read data (combinational) |
| rf_wr_en | output | 1 | Register-file write strobe |
| rf_wr_idx | output | 4 | Register-file write index |
| rf_wr_data | output | DATA_W | Register-file write data |
| sp_o | output | DATA_W | Working stack pointer |
| pc_o | output | DATA_W | Popped program counter with bit 0 cleared |
| flush_o | output | 1 | Pipeline flush request |
| done_o | output | 1 | One-cycle completion pulse |
| cnt_s | output | CNT_W | Sequential cycle count |
| cnt_n | output | CNT_W | Non-sequential cycle count |
| cnt_i | output | CNT_W | Internal cycle count |

## Verification
The bench builds the block with its defaults: an eight-bit list, 32-bit words and five-bit counters. These values allow the longest operation of nine words and the largest count, S = 9, so the full bitmap, each extra-register variant and the two empty cases can all be reached. The bench runs every command twice, once with ready always high and once with ready dropped at random. The second run stalls requests in the middle of a sequence and shows whether address, data and stack pointer hold still during the stall.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int REG_IDX_W = 4;
  localparam logic [REG_IDX_W-1:0] LINK_IDX = 4'd14;
  localparam logic [REG_IDX_W-1:0] PROG_IDX = 4'd15;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_DONE
  } stk_state_e;
endpackage

// File: rtl/stk_pick.sv
// Priority picker: lowest set bit, or highest set bit when hi_first.
module stk_pick #(
  parameter int W  = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  mask,
  input  logic          hi_first,
  output logic [IW-1:0] idx,
  output logic [W-1:0]  onehot,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = |mask;
    if (hi_first) begin
      for (int i = 0; i < W; i++)
        if (mask[i]) idx = IW'(i);
    end else begin
      for (int i = W - 1; i >= 0; i--)
        if (mask[i]) idx = IW'(i);
    end
    onehot = any ? (W'(1) << idx) : '0;
  end
endmodule

// File: rtl/stk_acct.sv
// Per-variant S/N/I cycle accounting computed from the command.
module stk_acct #(
  parameter int W     = 8,
  parameter int CNT_W = 5
) (
  input  logic [W-1:0]     list,
  input  logic             extra,
  input  logic             pop,
  output logic [CNT_W-1:0] s_cnt,
  output logic [CNT_W-1:0] n_cnt,
  output logic [CNT_W-1:0] i_cnt
);
  int listed;
  int words;

  always_comb begin
    listed = 0;
    for (int i = 0; i < W; i++)
      listed = listed + int'(list[i]);
    words = listed + int'(extra);
    s_cnt = '0;
    n_cnt = '0;
    i_cnt = '0;
    if (words != 0) begin
      if (pop && extra) begin
        s_cnt = CNT_W'(listed + 1);
        n_cnt = CNT_W'(2);
        i_cnt = CNT_W'(1);
      end else if (pop) begin
        s_cnt = CNT_W'(listed);
        n_cnt = CNT_W'(1);
        i_cnt = CNT_W'(1);
      end else begin
        s_cnt = CNT_W'(words - 1);
        n_cnt = CNT_W'(2);
      end
    end
  end
endmodule

// File: rtl/stk_multi_seq.sv
module stk_multi_seq
  import stk_pkg::*;
#(
  parameter int LIST_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [LIST_W-1:0]    cmd_list,
  input  logic                 cmd_extra,
  input  logic                 cmd_pop,
  input  logic [DATA_W-1:0]    cmd_sp,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic                 mem_req_write,
  output logic [DATA_W-1:0]    mem_req_addr,
  output logic [DATA_W-1:0]    mem_req_wdata,
  input  logic [DATA_W-1:0]    mem_rdata,
  output logic [REG_IDX_W-1:0] rf_rd_idx,
  input  logic [DATA_W-1:0]    rf_rd_data,
  output logic                 rf_wr_en,
  output logic [REG_IDX_W-1:0] rf_wr_idx,
  output logic [DATA_W-1:0]    rf_wr_data,
  output logic [DATA_W-1:0]    sp_o,
  output logic [DATA_W-1:0]    pc_o,
  output logic                 flush_o,
  output logic                 done_o,
  output logic [CNT_W-1:0]     cnt_s,
  output logic [CNT_W-1:0]     cnt_n,
  output logic [CNT_W-1:0]     cnt_i
);
  localparam int IW = (LIST_W > 1) ? $clog2(LIST_W) : 1;
  localparam logic [DATA_W-1:0] STEP = DATA_W'(DATA_W / 8);

  stk_state_e        state_q;
  logic [LIST_W-1:0] mask_q;
  logic              extra_q;
  logic              pop_q;
  logic [DATA_W-1:0] sp_q;
  logic [DATA_W-1:0] pc_q;
  logic              pc_hit_q;
  logic [CNT_W-1:0]  s_q, n_q, i_q;

  logic [IW-1:0]     pick_idx;
  logic [LIST_W-1:0] pick_hot;
  logic              pick_any;
  logic [CNT_W-1:0]  acc_s, acc_n, acc_i;

  logic              take_cmd;
  logic              accept;
  logic              use_extra;
  logic [REG_IDX_W-1:0] cur_idx;
  logic [LIST_W-1:0] rem_mask;
  logic              rem_extra;
  logic              is_last;

  stk_pick #(.W(LIST_W)) pick_i (
    .mask     (mask_q),
    .hi_first (~pop_q),
    .idx      (pick_idx),
    .onehot   (pick_hot),
    .any      (pick_any)
  );

  stk_acct #(.W(LIST_W), .CNT_W(CNT_W)) acct_i (
    .list  (cmd_list),
    .extra (cmd_extra),
    .pop   (cmd_pop),
    .s_cnt (acc_s),
    .n_cnt (acc_n),
    .i_cnt (acc_i)
  );

  // Slot selection: push puts the link register first, pop puts the PC last.
  always_comb begin
    if (pop_q) use_extra = ~pick_any;
    else       use_extra = extra_q;
    if (use_extra) cur_idx = pop_q ? PROG_IDX : LINK_IDX;
    else           cur_idx = REG_IDX_W'(pick_idx);
    rem_mask  = use_extra ? mask_q : (mask_q & ~pick_hot);
    rem_extra = use_extra ? 1'b0 : extra_q;
    is_last   = (rem_mask == '0) && !rem_extra;
  end

  assign cmd_ready     = (state_q == ST_IDLE);
  assign take_cmd      = cmd_valid && cmd_ready;
  assign mem_req_valid = (state_q == ST_XFER);
  assign accept        = mem_req_valid && mem_req_ready;
  assign mem_req_write = ~pop_q;
  assign mem_req_addr  = pop_q ? sp_q : (sp_q - STEP);
  assign mem_req_wdata = rf_rd_data;
  assign rf_rd_idx     = cur_idx;
  assign rf_wr_en      = accept && pop_q && !use_extra;
  assign rf_wr_idx     = cur_idx;
  assign rf_wr_data    = mem_rdata;
  assign sp_o          = sp_q;
  assign pc_o          = pc_q;
  assign done_o        = (state_q == ST_DONE);
  assign flush_o       = done_o && pc_hit_q;
  assign cnt_s         = s_q;
  assign cnt_n         = n_q;
  assign cnt_i         = i_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      mask_q   <= '0;
      extra_q  <= 1'b0;
      pop_q    <= 1'b0;
      sp_q     <= '0;
      pc_q     <= '0;
      pc_hit_q <= 1'b0;
      s_q      <= '0;
      n_q      <= '0;
      i_q      <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (take_cmd) begin
            mask_q   <= cmd_list;
            extra_q  <= cmd_extra;
            pop_q    <= cmd_pop;
            sp_q     <= cmd_sp;
            pc_hit_q <= 1'b0;
            s_q      <= acc_s;
            n_q      <= acc_n;
            i_q      <= acc_i;
            state_q  <= ((cmd_list == '0) && !cmd_extra) ? ST_DONE : ST_XFER;
          end
        end
        ST_XFER: begin
          if (accept) begin
            mask_q  <= rem_mask;
            extra_q <= rem_extra;
            sp_q    <= pop_q ? (sp_q + STEP) : (sp_q - STEP);
            if (pop_q && use_extra) begin
              pc_q     <= {mem_rdata[DATA_W-1:1], 1'b0};
              pc_hit_q <= 1'b1;
            end
            if (is_last) state_q <= ST_DONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stk_multi_seq_chk.sv
module stk_multi_seq_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [DATA_W-1:0] mem_req_addr,
  input logic [DATA_W-1:0] sp_o,
  input logic [DATA_W-1:0] pc_o,
  input logic              done_o,
  input logic              flush_o,
  input logic              rf_wr_en
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(DATA_W / 8);

  p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready && mem_req_write |=> sp_o == $past(sp_o) - STEP);

  p_pop_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready && !mem_req_write |=> sp_o == $past(sp_o) + STEP);

  p_rf_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |-> mem_req_valid && mem_req_ready && !mem_req_write);

  p_flush_pc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> done_o && !pc_o[0]);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_req_valid);

  p_hold_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(sp_o));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

bind stk_multi_seq stk_multi_seq_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/stk_multi_seq_tb_top.sv
module stk_multi_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_list = '0;
  logic        cmd_extra = 1'b0;
  logic        cmd_pop = 1'b0;
  logic [31:0] cmd_sp = '0;
  logic        mem_req_valid, mem_req_ready = 1'b0, mem_req_write;
  logic [31:0] mem_req_addr, mem_req_wdata, mem_rdata;
  logic [3:0]  rf_rd_idx, rf_wr_idx;
  logic [31:0] rf_rd_data, rf_wr_data, sp_o, pc_o;
  logic        rf_wr_en, flush_o, done_o;
  logic [4:0]  cnt_s, cnt_n, cnt_i;

  always #5 clk = ~clk;

  stk_multi_seq dut_i (.*);

  logic [31:0] regs [16];
  logic [31:0] mem  [256];
  assign rf_rd_data = regs[rf_rd_idx];
  assign mem_rdata  = mem[mem_req_addr[9:2]];
  always @(posedge clk) begin
    if (rf_wr_en) regs[rf_wr_idx] <= rf_wr_data;
    if (mem_req_valid && mem_req_ready && mem_req_write) mem[mem_req_addr[9:2]] <= mem_req_wdata;
  end

  typedef struct {
    logic [31:0] addr;
    bit          wr;
    logic [31:0] data;
    logic [3:0]  idx;
    string       tag;
  } acc_t;
  acc_t exp_q[$];

  int vectors = 0, errors = 0;
  bit stall_en = 0, busy = 0, done_seen = 0, prev_done = 0;
  logic [31:0] model_sp, exp_sp_fin, exp_pc;
  int exp_s, exp_n, exp_i;
  bit exp_flush;
  string done_tag;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference comparison on every clock.
  always @(negedge clk) begin
    mem_req_ready = stall_en ? (($urandom % 3) != 0) : 1'b1;
    #1;
    if (rst_n) begin
      if (prev_done) chk(done_o == 1'b0, "R10 done lasts one cycle", 32'(done_o), 0);
      prev_done = done_o;
      if (mem_req_valid) begin
        chk(cmd_ready == 1'b0, "R10 busy while transferring", 32'(cmd_ready), 0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected memory access", mem_req_addr, 0);
        end else begin
          acc_t h;
          h = exp_q[0];
          chk(mem_req_addr == h.addr, {h.tag, " address"}, mem_req_addr, h.addr);
          chk(mem_req_write == h.wr, {h.tag, " direction"}, 32'(mem_req_write), 32'(h.wr));
          chk(sp_o == model_sp, "R9 stack pointer held until accept", sp_o, model_sp);
          if (h.wr) chk(mem_req_wdata == h.data, {h.tag, " write data"}, mem_req_wdata, h.data);
          if (mem_req_ready) begin
            if (!h.wr) begin
              if (h.idx == 4'd15) begin
                exp_pc = {mem[h.addr[9:2]][31:1], 1'b0};
                chk(rf_wr_en == 1'b0, "R4 PC not written to register file", 32'(rf_wr_en), 0);
              end else begin
                chk(rf_wr_en && rf_wr_idx == h.idx, "R3 register-file index",
                    {27'd0, rf_wr_en, rf_wr_idx}, {28'd1, h.idx});
                chk(rf_wr_data == mem[h.addr[9:2]], "R3 register-file data",
                    rf_wr_data, mem[h.addr[9:2]]);
              end
            end
            model_sp = h.wr ? model_sp - 32'd4 : model_sp + 32'd4;
            void'(exp_q.pop_front());
          end
        end
      end else if (busy) begin
        chk(rf_wr_en == 1'b0, "R3 no write without access", 32'(rf_wr_en), 0);
      end
      if (done_o) begin
        chk(exp_q.size() == 0, {done_tag, " all words moved"}, exp_q.size(), 0);
        chk(sp_o == exp_sp_fin, {done_tag, " final stack pointer"}, sp_o, exp_sp_fin);
        chk(cnt_s == 5'(exp_s), {done_tag, " S count"}, 32'(cnt_s), exp_s);
        chk(cnt_n == 5'(exp_n), {done_tag, " N count"}, 32'(cnt_n), exp_n);
        chk(cnt_i == 5'(exp_i), {done_tag, " I count"}, 32'(cnt_i), exp_i);
        chk(flush_o == exp_flush, "R4 flush with done", 32'(flush_o), 32'(exp_flush));
        if (exp_flush) chk(pc_o == exp_pc, "R4 popped PC bit 0 cleared", pc_o, exp_pc);
        busy = 0;
        done_seen = 1;
      end else begin
        chk(flush_o == 1'b0, "R4 no flush outside done", 32'(flush_o), 0);
      end
    end
  end

  task automatic issue(input logic [7:0] l, input bit x, input bit p, input logic [31:0] sp);
    logic [31:0] s = sp;
    int listed = $countones(l);
    int words  = listed + int'(x);
    exp_q.delete();
    if (!p) begin
      if (x) begin s -= 4; exp_q.push_back('{s, 1'b1, regs[14], 4'd14, "R1 push link first"}); end
      for (int r = 7; r >= 0; r--)
        if (l[r]) begin s -= 4; exp_q.push_back('{s, 1'b1, regs[r], 4'(r), "R1 push descending"}); end
    end else begin
      for (int r = 0; r < 8; r++)
        if (l[r]) begin exp_q.push_back('{s, 1'b0, 32'd0, 4'(r), "R3 pop ascending"}); s += 4; end
      if (x) begin exp_q.push_back('{s, 1'b0, 32'd0, 4'd15, "R4 pop PC last"}); s += 4; end
    end
    exp_sp_fin = s;
    exp_flush  = p && x;
    if (words == 0)      begin exp_s = 0;          exp_n = 0; exp_i = 0; done_tag = "R8"; end
    else if (p && x)     begin exp_s = listed + 1; exp_n = 2; exp_i = 1; done_tag = "R6"; end
    else if (p)          begin exp_s = listed;     exp_n = 1; exp_i = 1; done_tag = "R5"; end
    else                 begin exp_s = words - 1;  exp_n = 2; exp_i = 0; done_tag = "R7"; end
    @(negedge clk);
    #2;
    while (!cmd_ready) begin @(negedge clk); #2; end
    cmd_valid = 1'b1; cmd_list = l; cmd_extra = x; cmd_pop = p; cmd_sp = sp;
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
    model_sp = sp; busy = 1; done_seen = 0;
    while (!done_seen) @(posedge clk);
  endtask

  task automatic pass_set;
    issue(8'h85, 0, 0, 32'h200);
    issue(8'h85, 0, 1, 32'h200 - 12);
    issue(8'hFF, 1, 0, 32'h300);
    issue(8'hFF, 1, 1, 32'h300 - 36);
    issue(8'h00, 0, 0, 32'h180);
    issue(8'h00, 0, 1, 32'h180);
    issue(8'h00, 1, 0, 32'h140);
    issue(8'h00, 1, 1, 32'h13C);
    issue(8'h01, 0, 0, 32'h100);
    issue(8'h01, 0, 1, 32'h0FC);
    for (int t = 0; t < 12; t++)
      issue(8'($urandom), 1'($urandom), 1'($urandom), 32'h200 + 32'(($urandom % 32) * 4));
  endtask

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 32'h1000_0001 + 32'(i * 32'h0111_0000);
    for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 + 32'(i * 3);
    repeat (3) @(posedge clk);
    #1;
    chk(cmd_ready == 1'b1 && mem_req_valid == 1'b0, "R11 idle during reset",
        {30'd0, cmd_ready, mem_req_valid}, 32'h2);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    chk(cmd_ready == 1'b1, "R11 ready after reset", 32'(cmd_ready), 1);
    chk(done_o == 1'b0 && flush_o == 1'b0, "R11 no done or flush after reset",
        {30'd0, done_o, flush_o}, 0);
    pass_set();
    stall_en = 1;
    pass_set();
    repeat (3) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule